// File: doc/BRIEF.md
# Input Switch Mute Sequencer

This block changes which of two serial digital audio inputs feeds the receiver without letting corrupted words reach the converter. The input multiplexer inside the receiver switches at once, so words in flight can be damaged. A switch is therefore never a bare change of the select line. The block first holds an external analog mute, waits a programmable settle time, and only then moves the select. Next it pulses the receiver's PLL/decoder reset and waits for lock to come back. It then holds the mute for one more settle time and releases it as the last step.

Requests carry a target input. A request that arrives while a sequence is running is held and served when that sequence ends. If lock does not return within a timeout, the block stays muted and flags an error until a new request starts a fresh attempt.

The controller is one state machine. Its states are IDLE, PREMUTE (mute on, settle before the switch), SWAP (the select moves), PLLRST (reset pulse), LOCKWAIT (wait for lock, with timeout), POSTMUTE (settle with lock held), RELEASE (mute off, done pulse) and FAULT (muted, error).

Its transitions are:
- IDLE→PREMUTE on a request for the other input.
- IDLE→RELEASE on a request for the current input.
- PREMUTE→SWAP when the settle time expires.
- SWAP→PLLRST after one cycle.
- PLLRST→LOCKWAIT when the pulse ends.
- LOCKWAIT→POSTMUTE when lock is seen.
- LOCKWAIT→FAULT on timeout.
- POSTMUTE→LOCKWAIT if lock drops.
- POSTMUTE→RELEASE when the settle time expires.
- RELEASE→IDLE.
- FAULT→PREMUTE on any request.

Top module: `srcsw_seq`

## Requirements
- R1: While reset is applied and after it is released, the outputs stay low until a request arrives: mute_out, pll_rst_out, busy, done and err are 0, and sel_out is 0 (input 0).
- R2: On a request for the input not currently selected, mute_out rises before sel_out changes, sel_out never changes while mute_out is 0, and mute_out is held for at least settle_len+1 cycles before sel_out changes.
- R3: After sel_out changes, pll_rst_out gives exactly one pulse of RST_CYCLES cycles, and mute_out stays high throughout it.
- R4: lock_in is ignored while pll_rst_out is high. Lock that is already high during the pulse does not shorten the pulse, and waiting for lock starts only after the pulse.
- R5: After lock is seen, mute_out stays high for at least settle_len+1 further cycles with lock held. If lock drops in this window, the block goes back to waiting for lock.
- R6: The mute is released together with a single-cycle done pulse. busy is 1 from the cycle after a request is accepted up to and including the done cycle.
- R7: A request whose target (req_sel: 0 = input 0, 1 = input 1) equals sel_out completes with a done pulse, with no mute and no reset pulse.
- R8: A request made while a sequence runs is latched and served after the current sequence completes. If several arrive, the latest target wins.
- R9: If synchronized lock is not seen within LOCK_TIMEOUT cycles after the reset pulse, the block enters the fault state. There mute_out=1, err=1 and busy=0. A new request, even for the input already selected, then runs the full mute, switch and reset sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle switch request strobe |
| req_sel | input | 1 | Requested input (0 or 1) |
| settle_len | input | SETTLE_W | Settle time in cycles, used before the switch and after relock |
| lock_in | input | 1 | Receiver lock indicator (synchronized inside) |
| sel_out | output | 1 | Input selection to the receiver |
| mute_out | output | 1 | External analog mute, active high |
| pll_rst_out | output | 1 | PLL/decoder reset pulse |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse when a sequence completes |
| err | output | 1 | Lock timeout, held until the next request |

## Verification
The bench attacks the ordering of the select change against the mute. A design that moved the select in the same cycle as the mute, or skipped the pre-switch settle, is caught by the mute-run count taken at every select change. It forces lock high through the reset pulse; a design that let lock cut the pulse short, or left the wait early, shows a short pulse. It sends a second request mid-sequence and a request for the current input. A design that dropped the latched request, or reset the PLL needlessly, produces the wrong number of completions or pulses. Holding lock low exposes a design that unmutes or stays busy on timeout. A same-input retry from fault exposes one that skips the reset.

// File: rtl/srcsw_pkg.sv
package srcsw_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PREMUTE,
        S_SWAP,
        S_PLLRST,
        S_LOCKWAIT,
        S_POSTMUTE,
        S_RELEASE,
        S_FAULT
    } seq_state_e;

    function automatic int wmax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/srcsw_sync.sv
module srcsw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);
    generate
        if (STAGES == 0) begin : g_bypass
            assign q_out = d_in;
        end else begin : g_chain
            logic [STAGES-1:0] chain_q;
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2 >= 0 ? STAGES-2 : 0 : 0], d_in};
            end
            assign q_out = chain_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/srcsw_timer.sv
module srcsw_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (load)          cnt_q <= load_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/srcsw_req_latch.sv
module srcsw_req_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_sel,
    input  logic take,
    output logic pend,
    output logic pend_sel
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend     <= 1'b0;
            pend_sel <= 1'b0;
        end else if (req_valid) begin
            pend     <= 1'b1;
            pend_sel <= req_sel;
        end else if (take) begin
            pend     <= 1'b0;
        end
    end
endmodule

// File: rtl/srcsw_seq.sv
module srcsw_seq
    import srcsw_pkg::*;
#(
    parameter int SETTLE_W     = 16,
    parameter int RST_CYCLES   = 8,
    parameter int LOCK_TIMEOUT = 4096,
    parameter int SYNC_STAGES  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_sel,
    input  logic [SETTLE_W-1:0] settle_len,
    input  logic                lock_in,
    output logic                sel_out,
    output logic                mute_out,
    output logic                pll_rst_out,
    output logic                busy,
    output logic                done,
    output logic                err
);
    localparam int TW_RST = $clog2(RST_CYCLES + 1);
    localparam int TW_TO  = $clog2(LOCK_TIMEOUT + 1);
    localparam int TMR_W  = wmax(wmax(SETTLE_W, TW_TO), TW_RST);
    localparam logic [TMR_W-1:0] RST_LOAD = TMR_W'(RST_CYCLES - 1);
    localparam logic [TMR_W-1:0] TO_LOAD  = TMR_W'(LOCK_TIMEOUT - 1);

    seq_state_e state_q, state_d;
    logic       take, pend, pend_sel;
    logic       tgt_q, sel_q;
    logic       lock_s;
    logic       tmr_load, tmr_exp;
    logic [TMR_W-1:0] tmr_val, settle_ext;

    assign settle_ext = TMR_W'(settle_len);

    srcsw_req_latch u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_sel  (req_sel),
        .take     (take),
        .pend     (pend),
        .pend_sel (pend_sel)
    );

    srcsw_sync #(.STAGES(SYNC_STAGES)) u_lock_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_in (lock_in),
        .q_out(lock_s)
    );

    srcsw_timer #(.W(TMR_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .expired (tmr_exp)
    );

    // next state and timer control
    always_comb begin
        state_d  = state_q;
        take     = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            S_IDLE: begin
                if (pend) begin
                    take = 1'b1;
                    if (pend_sel == sel_q) begin
                        state_d = S_RELEASE;
                    end else begin
                        state_d  = S_PREMUTE;
                        tmr_load = 1'b1;
                        tmr_val  = settle_ext;
                    end
                end
            end
            S_FAULT: begin
                if (pend) begin
                    take     = 1'b1;
                    state_d  = S_PREMUTE;
                    tmr_load = 1'b1;
                    tmr_val  = settle_ext;
                end
            end
            S_PREMUTE: begin
                if (tmr_exp) state_d = S_SWAP;
            end
            S_SWAP: begin
                state_d  = S_PLLRST;
                tmr_load = 1'b1;
                tmr_val  = RST_LOAD;
            end
            S_PLLRST: begin
                if (tmr_exp) begin
                    state_d  = S_LOCKWAIT;
                    tmr_load = 1'b1;
                    tmr_val  = TO_LOAD;
                end
            end
            S_LOCKWAIT: begin
                if (lock_s) begin
                    state_d  = S_POSTMUTE;
                    tmr_load = 1'b1;
                    tmr_val  = settle_ext;
                end else if (tmr_exp) begin
                    state_d = S_FAULT;
                end
            end
            S_POSTMUTE: begin
                if (!lock_s) begin
                    state_d  = S_LOCKWAIT;
                    tmr_load = 1'b1;
                    tmr_val  = TO_LOAD;
                end else if (tmr_exp) begin
                    state_d = S_RELEASE;
                end
            end
            S_RELEASE: begin
                state_d = S_IDLE;
            end
            default: begin
                state_d = S_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // target and selection registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q <= 1'b0;
            sel_q <= 1'b0;
        end else begin
            if (take)               tgt_q <= pend_sel;
            if (state_q == S_SWAP)  sel_q <= tgt_q;
        end
    end

    // outputs
    always_comb begin
        mute_out    = 1'b0;
        pll_rst_out = 1'b0;
        busy        = 1'b0;
        done        = 1'b0;
        err         = 1'b0;
        unique case (state_q)
            S_IDLE: begin
            end
            S_PREMUTE, S_SWAP, S_LOCKWAIT, S_POSTMUTE: begin
                mute_out = 1'b1;
                busy     = 1'b1;
            end
            S_PLLRST: begin
                mute_out    = 1'b1;
                pll_rst_out = 1'b1;
                busy        = 1'b1;
            end
            S_RELEASE: begin
                busy = 1'b1;
                done = 1'b1;
            end
            S_FAULT: begin
                mute_out = 1'b1;
                err      = 1'b1;
            end
            default: begin
            end
        endcase
    end

    assign sel_out = sel_q;
endmodule

// File: rtl/srcsw_chk.sv
module srcsw_chk #(
    parameter int RST_CYCLES = 8
) (
    input logic clk,
    input logic rst_n,
    input logic sel_out,
    input logic mute_out,
    input logic pll_rst_out,
    input logic busy,
    input logic done,
    input logic err
);
    int run_q, last_run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q      <= 0;
            last_run_q <= 0;
        end else if (pll_rst_out) begin
            run_q      <= run_q + 1;
            last_run_q <= run_q + 1;
        end else begin
            run_q <= 0;
        end
    end

    p_sel_muted_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sel_out) |-> (mute_out && $past(mute_out)));

    p_pll_muted_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pll_rst_out |-> mute_out);

    p_pulse_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pll_rst_out) |-> (last_run_q == RST_CYCLES));

    p_done_unmute_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!mute_out && !pll_rst_out && busy));

    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_fault_muted_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (mute_out && !busy));
endmodule

bind srcsw_seq srcsw_chk #(.RST_CYCLES(RST_CYCLES)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_out    (sel_out),
    .mute_out   (mute_out),
    .pll_rst_out(pll_rst_out),
    .busy       (busy),
    .done       (done),
    .err        (err)
);

// File: tb/srcsw_seq_tb_top.sv
`timescale 1ns/1ps
module srcsw_seq_tb_top;
    localparam int SW  = 8;
    localparam int RC  = 4;
    localparam int TO  = 40;

    typedef struct {
        bit is_fault;
        bit sel;
        int pulses;
        bit muted;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_sel = 1'b0;
    logic [SW-1:0] settle_len = 8'd5;
    logic          lock_in = 1'b1;
    logic          sel_out, mute_out, pll_rst_out, busy, done, err;

    int  n_chk = 0, n_fail = 0;
    int  lock_mode = 0;      // 0 model, 1 never, 2 always high
    int  lock_delay = 6;
    bit  reported = 1'b0;
    exp_t exp_q[$];

    always #2 clk = ~clk;

    srcsw_seq #(.SETTLE_W(SW), .RST_CYCLES(RC), .LOCK_TIMEOUT(TO), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sel(req_sel),
        .settle_len(settle_len), .lock_in(lock_in), .sel_out(sel_out),
        .mute_out(mute_out), .pll_rst_out(pll_rst_out), .busy(busy),
        .done(done), .err(err)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        end
    endtask

    // receiver lock model, driven just after each rising edge
    initial begin
        int lcnt = 0;
        forever begin
            @(posedge clk);
            #1;
            if (lock_mode == 1)      lock_in = 1'b0;
            else if (lock_mode == 2) lock_in = 1'b1;
            else if (pll_rst_out) begin
                lock_in = 1'b0;
                lcnt = 0;
            end else if (!lock_in) begin
                if (lcnt >= lock_delay) lock_in = 1'b1;
                else lcnt++;
            end
        end
    end

    // monitor and scoreboard
    initial begin
        bit   p_sel = 1'b0, p_pll = 1'b0, p_err = 1'b0, used_mute = 1'b0;
        int   mute_run = 0, pll_run = 0, pulses = 0, lock_run = 0;
        exp_t e;
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            mute_run = mute_out ? mute_run + 1 : 0;
            lock_run = lock_in  ? lock_run + 1 : 0;
            if (mute_out) used_mute = 1'b1;
            if (sel_out != p_sel) begin
                check(mute_out, "R2 mute at select change", mute_out, 1);
                check(mute_run >= int'(settle_len) + 2, "R2 pre-switch mute length",
                      mute_run, int'(settle_len) + 2);
            end
            if (pll_rst_out) begin
                if (!p_pll) pulses++;
                pll_run++;
            end else if (p_pll) begin
                check(pll_run == RC, "R3/R4 reset pulse width", pll_run, RC);
                pll_run = 0;
            end
            if (done || (err && !p_err)) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 unexpected completion", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    check(err == e.is_fault, "R9 completion kind", err, e.is_fault);
                    check(sel_out == e.sel, "R2 final selection", sel_out, e.sel);
                    check(pulses == e.pulses, "R7 reset pulse count", pulses, e.pulses);
                    check(used_mute == e.muted, "R7 mute used", used_mute, e.muted);
                    if (done) begin
                        check(!mute_out, "R6 mute released at done", mute_out, 0);
                        if (e.muted)
                            check(lock_run >= int'(settle_len) + 1, "R5 post-lock settle",
                                  lock_run, int'(settle_len) + 1);
                    end else begin
                        check(mute_out, "R9 mute held on fault", mute_out, 1);
                    end
                end
                pulses = 0;
                used_mute = 1'b0;
            end
            p_sel = sel_out;
            p_pll = pll_rst_out;
            p_err = err;
        end
    end

    task automatic push(input bit f, input bit s, input int p, input bit m);
        exp_t e;
        e.is_fault = f; e.sel = s; e.pulses = p; e.muted = m;
        exp_q.push_back(e);
    endtask

    task automatic send(input bit s);
        @(negedge clk);
        req_valid = 1'b1;
        req_sel   = s;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_quiet();
        int q = 0;
        while (q < 4) begin
            @(negedge clk);
            if (busy) q = 0;
            else q++;
        end
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!mute_out && !pll_rst_out && !busy && !done && !err && !sel_out,
              "R1 outputs in reset", {mute_out, pll_rst_out, busy, done, err, sel_out}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!mute_out && !pll_rst_out && !busy && !done && !err && !sel_out,
              "R1 outputs after reset", {mute_out, pll_rst_out, busy, done, err, sel_out}, 0);

        // R2 R3 R5 R6: normal switch to input 1
        push(0, 1, 1, 1); send(1); wait_quiet();
        // zero settle time, back to input 0
        settle_len = 8'd0;
        push(0, 0, 1, 1); send(0); wait_quiet();
        // R7: same input
        settle_len = 8'd3;
        push(0, 0, 0, 0); send(0); wait_quiet();
        // R8: request during a running sequence, latest wins
        push(0, 1, 1, 1); push(0, 0, 1, 1);
        send(1); repeat (3) @(negedge clk);
        send(1); send(0);
        wait_quiet();
        check(sel_out == 1'b0, "R8 latest request served", sel_out, 0);
        // R4: lock high throughout the reset pulse
        lock_mode = 2;
        push(0, 1, 1, 1); send(1); wait_quiet();
        // R9: lock never returns
        lock_mode = 1;
        push(1, 0, 1, 1); send(0); wait_quiet();
        repeat (10) @(negedge clk);
        check(mute_out && err && !busy, "R9 fault state held", {mute_out, err, busy}, 3'b110);
        // R9: retry to same input runs full sequence
        lock_mode = 0; lock_delay = 3;
        push(0, 0, 1, 1); send(0); wait_quiet();
        check(!err && !mute_out, "R9 recovered", {err, mute_out}, 0);
        check(exp_q.size() == 0, "R8 all expected completions seen", exp_q.size(), 0);
        report();
        $finish;
    end
endmodule